// File: doc/BRIEF.md
# Majority Macro-Command Expander

This block sits between a command source and the controller that runs primitive resistive-majority instructions on a memory array. Each primitive names three cell addresses, A, B and Z. It rewrites the Z cell with the three-input majority of A, the inverse of B, and the old Z. The expander takes one high-level command at a time: clear, set, copy, invert or general majority. It emits the short, fixed sequence of primitives that performs that command. The destination cell is the only cell that any sequence alters.

Two reserved addresses supply constant values. Address 0 reads as logic 0 and address 1 reads as logic 1. Addresses 2 up to 2+PI_COUNT-1 hold primary inputs, which must never be overwritten. Together, the two constants and the primary inputs form the protected range below `2+PI_COUNT`.

Both sides use valid/ready. A command transfers on a cycle where `cmd_valid` and `cmd_ready` are both high. A primitive transfers on a cycle where `prim_valid` and `prim_ready` are both high. While `prim_ready` is low, the presented primitive is held unchanged. `cmd_ready` stays low until the last primitive of the current command has transferred, so the command side sees back-pressure for as long as the output side does.

Top module: `maj_cmd_expander`

## Requirements
- R1: Opcode 0 (clear) with destination z emits one primitive: A=0, B=1, Z=z.
- R2: Opcode 1 (set) emits one primitive: A=1, B=0, Z=z.
- R3: Opcode 2 (copy a into z) emits two primitives in this order: (A=0, B=1, Z=z), then (A=a, B=0, Z=z).
- R4: Opcode 3 (invert a into z) emits two primitives in this order: (A=0, B=1, Z=z), then (A=1, B=a, Z=z).
- R5: Opcode 4 (majority) emits one primitive: A=a, B=b, Z=z.
- R6: While `prim_valid` is high and `prim_ready` is low, `prim_valid` stays high and `prim_a`, `prim_b` and `prim_z` hold their values.
- R7: `cmd_ready` is low from the cycle after a valid command is accepted until its final primitive transfers, and it is high again in the cycle after that transfer.
- R8: Opcodes 5, 6 and 7 are accepted without emitting any primitive, and `err_flag` is high for exactly the cycle after acceptance.
- R9: A command whose z is below 2+PI_COUNT is accepted without emitting any primitive, and `err_flag` pulses as in R8. No emitted primitive has Z in that range.
- R10: After reset, `prim_valid` and `err_flag` are low and `cmd_ready` is high.
- R11: The first primitive of an accepted valid command is presented in the cycle right after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Expander can take a command |
| cmd_op | input | 3 | Command opcode |
| cmd_a | input | ADDR_W | First source address |
| cmd_b | input | ADDR_W | Second source address (majority only) |
| cmd_z | input | ADDR_W | Destination address |
| prim_valid | output | 1 | Primitive presented |
| prim_ready | input | 1 | Downstream takes the primitive |
| prim_a | output | ADDR_W | Primitive A (top electrode) address |
| prim_b | output | ADDR_W | Primitive B (bottom electrode) address |
| prim_z | output | ADDR_W | Primitive Z (destination) address |
| err_flag | output | 1 | One-cycle pulse for a rejected command |

## Verification
Directed commands cover every opcode. They use source addresses that coincide with the constant cells, so a swapped A/B pair or a missing clear step shows up as a wrong address. Destinations sit at the first legal address, at the last protected address and at the top of the address space. These separate a correct range comparison from one that is off by one. A long stream of commands then follows, with random opcodes, random addresses and random stalls on `prim_ready`. It tells apart correct ordering and holding of two-step sequences from designs that advance or re-accept while the output is stalled.

// File: rtl/mce_pkg.sv
package mce_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_CLEAR  = 3'd0,
    OP_SET    = 3'd1,
    OP_COPY   = 3'd2,
    OP_INVERT = 3'd3,
    OP_MAJ    = 3'd4
  } macro_op_e;
endpackage

// File: rtl/mce_decode.sv
module mce_decode
  import mce_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int PI_COUNT = 6
) (
  input  logic [OP_W-1:0]   op,
  input  logic [ADDR_W-1:0] src_a,
  input  logic [ADDR_W-1:0] src_b,
  input  logic [ADDR_W-1:0] dst_z,
  output logic [ADDR_W-1:0] s0_a,
  output logic [ADDR_W-1:0] s0_b,
  output logic [ADDR_W-1:0] s1_a,
  output logic [ADDR_W-1:0] s1_b,
  output logic              two_step,
  output logic              reject
);
  localparam logic [ADDR_W-1:0] K0   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] K1   = ADDR_W'(1);
  localparam int                PROT = 2 + PI_COUNT;

  logic known_op;
  logic dst_locked;

  generate
    if (PROT >= (1 << ADDR_W)) begin : g_all_locked
      assign dst_locked = 1'b1;
    end else begin : g_range
      assign dst_locked = (dst_z < ADDR_W'(PROT));
    end
  endgenerate

  always_comb begin
    s0_a     = K0;
    s0_b     = K1;
    s1_a     = K0;
    s1_b     = K1;
    two_step = 1'b0;
    known_op = 1'b1;
    case (op)
      OP_CLEAR: begin
        s0_a = K0;
        s0_b = K1;
      end
      OP_SET: begin
        s0_a = K1;
        s0_b = K0;
      end
      OP_COPY: begin
        two_step = 1'b1;
        s1_a     = src_a;
        s1_b     = K0;
      end
      OP_INVERT: begin
        two_step = 1'b1;
        s1_a     = K1;
        s1_b     = src_a;
      end
      OP_MAJ: begin
        s0_a = src_a;
        s0_b = src_b;
      end
      default: known_op = 1'b0;
    endcase
    reject = !known_op || dst_locked;
  end
endmodule

// File: rtl/mce_seq.sv
module mce_seq #(
  parameter int ADDR_W = 6,
  parameter int STEPS  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              reject,
  input  logic              two_step,
  input  logic [ADDR_W-1:0] s0_a,
  input  logic [ADDR_W-1:0] s0_b,
  input  logic [ADDR_W-1:0] s1_a,
  input  logic [ADDR_W-1:0] s1_b,
  input  logic [ADDR_W-1:0] dst_z,
  input  logic              out_ready,
  output logic              busy,
  output logic [ADDR_W-1:0] out_a,
  output logic [ADDR_W-1:0] out_b,
  output logic [ADDR_W-1:0] out_z,
  output logic              err_pulse
);
  localparam int IDX_W = (STEPS > 1) ? $clog2(STEPS) : 1;

  logic [ADDR_W-1:0] slot_a [STEPS];
  logic [ADDR_W-1:0] slot_b [STEPS];
  logic [ADDR_W-1:0] slot_z;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  last_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      idx       <= '0;
      last_idx  <= '0;
      slot_z    <= '0;
      err_pulse <= 1'b0;
      for (int i = 0; i < STEPS; i++) begin
        slot_a[i] <= '0;
        slot_b[i] <= '0;
      end
    end else begin
      err_pulse <= take && reject;
      if (take && !reject) begin
        busy      <= 1'b1;
        idx       <= '0;
        last_idx  <= two_step ? IDX_W'(1) : IDX_W'(0);
        slot_z    <= dst_z;
        slot_a[0] <= s0_a;
        slot_b[0] <= s0_b;
        slot_a[1] <= s1_a;
        slot_b[1] <= s1_b;
      end else if (busy && out_ready) begin
        if (idx == last_idx) begin
          busy <= 1'b0;
          idx  <= '0;
        end else begin
          idx <= idx + IDX_W'(1);
        end
      end
    end
  end

  assign out_a = slot_a[idx];
  assign out_b = slot_b[idx];
  assign out_z = slot_z;
endmodule

// File: rtl/maj_cmd_expander.sv
module maj_cmd_expander
  import mce_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int PI_COUNT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic [ADDR_W-1:0] cmd_a,
  input  logic [ADDR_W-1:0] cmd_b,
  input  logic [ADDR_W-1:0] cmd_z,
  output logic              prim_valid,
  input  logic              prim_ready,
  output logic [ADDR_W-1:0] prim_a,
  output logic [ADDR_W-1:0] prim_b,
  output logic [ADDR_W-1:0] prim_z,
  output logic              err_flag
);
  logic [ADDR_W-1:0] d_s0_a, d_s0_b, d_s1_a, d_s1_b;
  logic              d_two, d_reject, busy, take;

  mce_decode #(.ADDR_W(ADDR_W), .PI_COUNT(PI_COUNT)) decode_i (
    .op(cmd_op), .src_a(cmd_a), .src_b(cmd_b), .dst_z(cmd_z),
    .s0_a(d_s0_a), .s0_b(d_s0_b), .s1_a(d_s1_a), .s1_b(d_s1_b),
    .two_step(d_two), .reject(d_reject)
  );

  assign cmd_ready = !busy;
  assign take      = cmd_valid && cmd_ready;

  mce_seq #(.ADDR_W(ADDR_W), .STEPS(2)) seq_i (
    .clk(clk), .rst_n(rst_n), .take(take), .reject(d_reject),
    .two_step(d_two), .s0_a(d_s0_a), .s0_b(d_s0_b),
    .s1_a(d_s1_a), .s1_b(d_s1_b), .dst_z(cmd_z),
    .out_ready(prim_ready), .busy(busy),
    .out_a(prim_a), .out_b(prim_b), .out_z(prim_z),
    .err_pulse(err_flag)
  );

  assign prim_valid = busy;
endmodule

// File: rtl/mce_checker.sv
module mce_checker #(
  parameter int ADDR_W = 6,
  parameter int PROT   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              prim_valid,
  input logic              prim_ready,
  input logic [ADDR_W-1:0] prim_a,
  input logic [ADDR_W-1:0] prim_b,
  input logic [ADDR_W-1:0] prim_z,
  input logic              err_flag
);
  logic seen;
  always_ff @(posedge clk) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prim_valid && !prim_ready |=> prim_valid && $stable(prim_a) && $stable(prim_b) && $stable(prim_z));

  // R7
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prim_valid |-> !cmd_ready);

  // R8
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |-> !prim_valid);

  // R9
  dest_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prim_valid |-> (int'(prim_z) >= PROT));

  // R11
  start_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(cmd_valid && cmd_ready) && !err_flag |-> prim_valid);
endmodule

bind maj_cmd_expander mce_checker #(.ADDR_W(ADDR_W), .PROT(2 + PI_COUNT)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .prim_valid(prim_valid), .prim_ready(prim_ready),
  .prim_a(prim_a), .prim_b(prim_b), .prim_z(prim_z), .err_flag(err_flag)
);

// File: tb/maj_cmd_expander_tb_top.sv
`timescale 1ns/1ps
module maj_cmd_expander_tb_top;
  localparam int AW   = 6;
  localparam int PIC  = 6;
  localparam int PROT = 2 + PIC;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [2:0]    cmd_op = '0;
  logic [AW-1:0] cmd_a = '0, cmd_b = '0, cmd_z = '0;
  logic          prim_valid;
  logic          prim_ready = 1'b0;
  logic [AW-1:0] prim_a, prim_b, prim_z;
  logic          err_flag;

  int total = 0;
  int bad_cnt = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  maj_cmd_expander #(.ADDR_W(AW), .PI_COUNT(PIC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_a(cmd_a), .cmd_b(cmd_b), .cmd_z(cmd_z),
    .prim_valid(prim_valid), .prim_ready(prim_ready),
    .prim_a(prim_a), .prim_b(prim_b), .prim_z(prim_z), .err_flag(err_flag)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad_cnt++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_count(int op, int z);
    if (op > 4 || z < PROT) return 0;
    if (op == 2 || op == 3) return 2;
    return 1;
  endfunction

  function automatic int exp_field(int op, int a, int b, int z, int idx, int sel);
    int ea, eb;
    case (op)
      0: begin ea = 0; eb = 1; end
      1: begin ea = 1; eb = 0; end
      2: if (idx == 0) begin ea = 0; eb = 1; end else begin ea = a; eb = 0; end
      3: if (idx == 0) begin ea = 0; eb = 1; end else begin ea = 1; eb = a; end
      default: begin ea = a; eb = b; end
    endcase
    if (sel == 0) return ea;
    if (sel == 1) return eb;
    return z;
  endfunction

  function automatic string req_of(int op, int z);
    if (op > 4) return "R8";
    if (z < PROT) return "R9";
    case (op)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic run_cmd(int op, int a, int b, int z);
    int n;
    string rq;
    bit r;
    rq = req_of(op, z);
    n  = exp_count(op, z);
    @(negedge clk);
    cmd_op = op[2:0]; cmd_a = a[AW-1:0]; cmd_b = b[AW-1:0]; cmd_z = z[AW-1:0];
    cmd_valid = 1'b1;
    prim_ready = 1'b0;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (n == 0) begin
      chk(err_flag == 1'b1, rq, "err_flag after reject", int'(err_flag), 1);
      chk(prim_valid == 1'b0, rq, "prim_valid after reject", int'(prim_valid), 0);
      @(negedge clk);
      chk(err_flag == 1'b0, rq, "err_flag one cycle only", int'(err_flag), 0);
      chk(prim_valid == 1'b0, rq, "no primitive on reject", int'(prim_valid), 0);
    end else begin
      chk(err_flag == 1'b0, rq, "no err on valid cmd", int'(err_flag), 0);
      // R11: first primitive visible right after acceptance
      chk(prim_valid == 1'b1, "R11", "prim_valid after accept", int'(prim_valid), 1);
      for (int i = 0; i < n; i++) begin
        r = 1'b0;
        while (!r) begin
          // R6: each stalled cycle re-checks the held primitive
          chk(prim_valid == 1'b1, rq, "prim_valid", int'(prim_valid), 1);
          chk(int'(prim_a) == exp_field(op, a, b, z, i, 0), rq, "prim_a", int'(prim_a), exp_field(op, a, b, z, i, 0));
          chk(int'(prim_b) == exp_field(op, a, b, z, i, 1), rq, "prim_b", int'(prim_b), exp_field(op, a, b, z, i, 1));
          chk(int'(prim_z) == z, rq, "prim_z", int'(prim_z), z);
          chk(cmd_ready == 1'b0, "R7", "cmd_ready while busy", int'(cmd_ready), 0);
          r = ($urandom % 3) != 0;
          prim_ready = r;
          @(negedge clk);
        end
      end
      prim_ready = 1'b0;
      chk(prim_valid == 1'b0, rq, "sequence length", int'(prim_valid), 0);
      chk(cmd_ready == 1'b1, "R7", "cmd_ready after last", int'(cmd_ready), 1);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R10
    chk(prim_valid == 1'b0, "R10", "prim_valid in reset", int'(prim_valid), 0);
    chk(err_flag == 1'b0, "R10", "err_flag in reset", int'(err_flag), 0);
    chk(cmd_ready == 1'b1, "R10", "cmd_ready in reset", int'(cmd_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(prim_valid == 1'b0, "R10", "prim_valid after reset", int'(prim_valid), 0);

    run_cmd(0, 5, 9, PROT);      // R1, lowest legal destination
    run_cmd(1, 0, 0, 63);        // R2, top address
    run_cmd(2, 1, 0, 20);        // R3, source is constant 1
    run_cmd(2, 3, 0, 21);        // R3, source is a primary input
    run_cmd(3, 0, 0, 22);        // R4, source is constant 0
    run_cmd(3, 40, 0, 23);       // R4
    run_cmd(4, 0, 1, 30);        // R5, constants as operands
    run_cmd(4, 12, 50, 31);      // R5
    run_cmd(5, 2, 3, 30);        // R8
    run_cmd(7, 2, 3, 30);        // R8
    run_cmd(0, 2, 3, PROT - 1);  // R9, last protected address
    run_cmd(2, 9, 3, 0);         // R9, constant cell as destination
    for (int k = 0; k < 400; k++) begin
      int op, a, b, z;
      op = (($urandom % 8) < 6) ? int'($urandom % 5) : int'($urandom % 8);
      a  = int'($urandom % 64);
      b  = int'($urandom % 64);
      z  = (($urandom % 6) == 0) ? int'($urandom % PROT) : int'($urandom % 64);
      run_cmd(op, a, b, z);
    end
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad_cnt);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      chk(1'b0, "R7", "watchdog expired", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad_cnt);
      $finish;
    end
  end
endmodule